// File: doc/BRIEF.md
# Page Entry Cache with Ranged Sweep Invalidation

This block holds a handful of recently used page table entries in front of an address translation walker. Every line is keyed by the real memory address of the entry it copies. A lookup searches all lines in parallel and returns the cached entry in the same cycle. A fill from the walker writes a new entry: it overwrites the line that already holds that address, or otherwise takes the line the round-robin pointer selects.

Software removes stale entries by writing a single 64-bit command word. The word holds a starting entry address, a count of 8-byte entries and a busy flag. Writing the flag as 1 starts a sweep. The sweep visits every line once, one line per cycle, and drops each valid line whose tag falls in the window. The block then returns the flag to 0, and software polls for that. Lookups and fills are held off while a sweep runs, so no line that the sweep is about to drop can be returned in the meantime.

Top module: `page_entry_cache`

## Requirements
- R1: After reset every line is invalid, `cmd_rdata` reads all zeros, and `lk_ready` and `fill_ready` are high.
- R2: When idle, a lookup whose address bits 41:3 equal the tag of a valid line raises `lk_hit` in the same cycle and drives that line's data. Any other lookup gives `lk_hit` low and `lk_data` zero. Address bits 2:0 are ignored.
- R3: A fill to a tag that is already resident replaces that line's data in place. It leaves every other line alone and does not move the replacement pointer. No two valid lines ever share a tag.
- R4: A fill to a tag that is not resident writes the line at the replacement pointer. The pointer starts at line 0 and advances by one modulo NLINES on each such fill, whether or not the chosen line was valid.
- R5: The command word carries an 11-bit count in bits 63:53, the starting entry address in bits 41:3, and the busy flag in bit 0. A write accepted while idle stores the count and the start. Reading `cmd_rdata` returns those two fields in place, bit 0 as the live busy flag, and zeros elsewhere. A write with bit 0 clear only stores the fields.
- R6: An accepted write with bit 0 set and a nonzero count makes the busy flag read 1 from the next cycle for exactly NLINES cycles, after which it reads 0.
- R7: After a sweep, every line whose tag t satisfies start ≤ t < start + count is invalid. The arithmetic is done without wrap-around. All other lines keep their tag and data.
- R8: An accepted write with bit 0 set and a count of zero leaves the busy flag at 0 on the following cycle and invalidates nothing.
- R9: A command write that arrives while the busy flag is 1 is ignored. The stored fields do not change and the sweep is not restarted or extended.
- R10: While the busy flag is 1, `lk_ready` and `fill_ready` are low. A lookup in that time reports no hit, and a fill in that time changes no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 42 | Real address of the wanted entry |
| lk_ready | output | 1 | Lookups accepted (low during a sweep) |
| lk_hit | output | 1 | Lookup found a valid line |
| lk_data | output | DATA_W | Cached entry on a hit, zero otherwise |
| fill_valid | input | 1 | Fill request from the walker |
| fill_addr | input | 42 | Real address of the entry being filled |
| fill_data | input | DATA_W | Entry value to store |
| fill_ready | output | 1 | Fills accepted (low during a sweep) |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 64 | Command word written by software |
| cmd_rdata | output | 64 | Command word readback with live busy flag |

## Verification
The bench sweeps every window start from below the cached run to above it, with every count from zero up past the run length. A comparison that is off by one would keep the line at the window's top or drop the line just past it. A window that reaches the top of the 39-bit tag space is also tried, because a sum that wraps would make the window empty and drop nothing. Commands written mid-sweep and fills issued mid-sweep are included, since a design that takes either would restart the sweep, stretch the busy time, or slip a new line into the cache. Replacement order is followed fill by fill against a reference model. A design that advances its pointer on an in-place update would then evict the wrong line.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int ADDR_W  = 42;
  localparam int TAG_LSB = 3;
  localparam int TAG_W   = ADDR_W - TAG_LSB;
  localparam int CNT_W   = 11;
  localparam int CNT_LSB = 53;
  localparam int CMD_W   = 64;

  // True when tag lies in [start, start + cnt), computed one bit wider so it never wraps.
  function automatic logic in_window(input logic [TAG_W-1:0] tag,
                                     input logic [TAG_W-1:0] start,
                                     input logic [CNT_W-1:0] cnt);
    logic [TAG_W:0] lo;
    logic [TAG_W:0] hi;
    lo = {1'b0, start};
    hi = lo + {{(TAG_W + 1 - CNT_W){1'b0}}, cnt};
    return ({1'b0, tag} >= lo) && ({1'b0, tag} < hi);
  endfunction

  // Readback image of the command word.
  function automatic logic [CMD_W-1:0] cmd_image(input logic [TAG_W-1:0] start,
                                                 input logic [CNT_W-1:0] cnt,
                                                 input logic busy);
    logic [CMD_W-1:0] w;
    w = '0;
    w[CNT_LSB +: CNT_W] = cnt;
    w[TAG_LSB +: TAG_W] = start;
    w[0] = busy;
    return w;
  endfunction
endpackage

// File: rtl/pec_line_store.sv
module pec_line_store
  import pec_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int DATA_W = 64,
  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [TAG_W-1:0]  fl_tag,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_en,
  input  logic [IW-1:0]     scan_idx,
  output logic [NLINES-1:0] lk_match,
  output logic [NLINES-1:0] fl_match,
  output logic [DATA_W-1:0] lk_data,
  output logic              scan_valid,
  output logic [TAG_W-1:0]  scan_tag
);
  logic [NLINES-1:0] vld_q;
  logic [TAG_W-1:0]  tag_q [NLINES];
  logic [DATA_W-1:0] dat_q [NLINES];

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic wr_here;
    logic clr_here;
    assign wr_here  = wr_en && (wr_idx == IW'(i));
    assign clr_here = clr_en && (scan_idx == IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end else if (wr_here) begin
        vld_q[i] <= 1'b1;
        tag_q[i] <= fl_tag;
        dat_q[i] <= wr_data;
      end else if (clr_here) begin
        vld_q[i] <= 1'b0;
      end
    end

    assign lk_match[i] = vld_q[i] && (tag_q[i] == lk_tag);
    assign fl_match[i] = vld_q[i] && (tag_q[i] == fl_tag);
  end

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (lk_match[i]) lk_data = lk_data | dat_q[i];
    end
  end

  assign scan_valid = vld_q[scan_idx];
  assign scan_tag   = tag_q[scan_idx];
endmodule

// File: rtl/pec_victim.sv
module pec_victim #(
  parameter int NLINES = 8,
  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [IW-1:0] ptr
);
  localparam logic [IW-1:0] LAST = IW'(NLINES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/pec_sweep.sv
module pec_sweep
  import pec_pkg::*;
#(
  parameter int NLINES = 8,
  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             scan_valid,
  input  logic [TAG_W-1:0] scan_tag,
  output logic             busy,
  output logic [CMD_W-1:0] cmd_rdata,
  output logic [IW-1:0]    scan_idx,
  output logic             kill
);
  localparam logic [IW-1:0] LAST = IW'(NLINES - 1);

  logic [TAG_W-1:0] start_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [IW-1:0]    idx_q;
  logic             accept;
  logic             launch;
  logic [CNT_W-1:0] wr_cnt;

  assign accept = cmd_we && !busy_q;
  assign wr_cnt = cmd_wdata[CNT_LSB +: CNT_W];
  assign launch = accept && cmd_wdata[0] && (wr_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      if (accept) begin
        start_q <= cmd_wdata[TAG_LSB +: TAG_W];
        cnt_q   <= wr_cnt;
      end
      if (launch) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (busy_q) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == LAST) busy_q <= 1'b0;
      end
    end
  end

  assign busy      = busy_q;
  assign scan_idx  = idx_q;
  assign kill      = busy_q && scan_valid && in_window(scan_tag, start_q, cnt_q);
  assign cmd_rdata = cmd_image(start_q, cnt_q, busy_q);
endmodule

// File: rtl/page_entry_cache.sv
module page_entry_cache
  import pec_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int DATA_W = 64,
  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_ready,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              fill_ready,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_wdata,
  output logic [CMD_W-1:0]  cmd_rdata
);
  // Named internal events for the checker.
  logic              sweep_busy;
  logic              sweep_kill;
  logic              fill_go;
  logic              fill_resident;
  logic [NLINES-1:0] lk_match_vec;
  logic [NLINES-1:0] fl_match_vec;

  logic [IW-1:0]     victim_ptr;
  logic [IW-1:0]     resident_idx;
  logic [IW-1:0]     write_idx;
  logic [IW-1:0]     scan_idx;
  logic              scan_valid;
  logic [TAG_W-1:0]  scan_tag;
  logic [DATA_W-1:0] store_data;

  assign fill_go       = fill_valid && !sweep_busy;
  assign fill_resident = |fl_match_vec;

  always_comb begin
    resident_idx = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (fl_match_vec[i]) resident_idx = IW'(i);
    end
  end

  assign write_idx = fill_resident ? resident_idx : victim_ptr;

  pec_line_store #(.NLINES(NLINES), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_tag     (lk_addr[ADDR_W-1:TAG_LSB]),
    .fl_tag     (fill_addr[ADDR_W-1:TAG_LSB]),
    .wr_en      (fill_go),
    .wr_idx     (write_idx),
    .wr_data    (fill_data),
    .clr_en     (sweep_kill),
    .scan_idx   (scan_idx),
    .lk_match   (lk_match_vec),
    .fl_match   (fl_match_vec),
    .lk_data    (store_data),
    .scan_valid (scan_valid),
    .scan_tag   (scan_tag)
  );

  pec_victim #(.NLINES(NLINES)) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (fill_go && !fill_resident),
    .ptr     (victim_ptr)
  );

  pec_sweep #(.NLINES(NLINES)) u_sweep (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .cmd_wdata  (cmd_wdata),
    .scan_valid (scan_valid),
    .scan_tag   (scan_tag),
    .busy       (sweep_busy),
    .cmd_rdata  (cmd_rdata),
    .scan_idx   (scan_idx),
    .kill       (sweep_kill)
  );

  assign lk_ready   = !sweep_busy;
  assign fill_ready = !sweep_busy;
  assign lk_hit     = lk_valid && !sweep_busy && (|lk_match_vec);
  assign lk_data    = lk_hit ? store_data : '0;
endmodule

// File: rtl/page_entry_cache_chk.sv
module page_entry_cache_chk #(
  parameter int NLINES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              lk_ready,
  input logic              fill_ready,
  input logic              cmd_we,
  input logic [63:0]       cmd_wdata,
  input logic [63:0]       cmd_rdata,
  input logic [NLINES-1:0] lk_match,
  input logic [NLINES-1:0] fl_match
);
  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!lk_ready && !fill_ready));

  assert_unique_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match) && $onehot0(fl_match));

  assert_sweep_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == NLINES));

  assert_sweep_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !busy && cmd_wdata[0] && (cmd_wdata[63:53] != 11'd0)) |=> busy);

  assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !busy && cmd_wdata[0] && (cmd_wdata[63:53] == 11'd0)) |=> !busy);

  assert_ignored_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && busy) |=> (cmd_rdata[63:1] == $past(cmd_rdata[63:1])));
endmodule

bind page_entry_cache page_entry_cache_chk #(.NLINES(NLINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (sweep_busy),
  .lk_ready   (lk_ready),
  .fill_ready (fill_ready),
  .cmd_we     (cmd_we),
  .cmd_wdata  (cmd_wdata),
  .cmd_rdata  (cmd_rdata),
  .lk_match   (lk_match_vec),
  .fl_match   (fl_match_vec)
);

// File: tb/page_entry_cache_bench.sv
`timescale 1ns/1ps
module page_entry_cache_bench;
  localparam int N  = 8;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic [41:0]   lk_addr = '0;
  logic          lk_ready;
  logic          lk_hit;
  logic [DW-1:0] lk_data;
  logic          fill_valid = 1'b0;
  logic [41:0]   fill_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic          fill_ready;
  logic          cmd_we = 1'b0;
  logic [63:0]   cmd_wdata = '0;
  logic [63:0]   cmd_rdata;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  page_entry_cache #(.NLINES(N), .DATA_W(DW)) u_page_entry_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_ready(lk_ready),
    .lk_hit(lk_hit), .lk_data(lk_data),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .fill_ready(fill_ready),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata)
  );

  // Reference model of the line contents.
  bit          m_v [N];
  bit [38:0]   m_t [N];
  bit [DW-1:0] m_d [N];
  int          m_ptr;

  function automatic bit [DW-1:0] pat(bit [38:0] t, int seed);
    return {seed[7:0], 17'h0, t} ^ 64'h3C5A_0000_F00D_0001;
  endfunction

  function automatic bit [63:0] mkcmd(bit [38:0] st, bit [10:0] c, bit b);
    bit [63:0] w;
    w = '0;
    w[63:53] = c;
    w[41:3] = st;
    w[0] = b;
    return w;
  endfunction

  task automatic check(string req, bit [63:0] act, bit [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_fill(bit [38:0] t, bit [DW-1:0] d);
    int hit_i;
    hit_i = -1;
    for (int i = 0; i < N; i++) if (m_v[i] && m_t[i] == t) hit_i = i;
    if (hit_i >= 0) m_d[hit_i] = d;
    else begin
      m_v[m_ptr] = 1'b1; m_t[m_ptr] = t; m_d[m_ptr] = d;
      m_ptr = (m_ptr + 1) % N;
    end
  endtask

  task automatic fill(bit [38:0] t, bit [DW-1:0] d, bit upd);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = {t, 3'b101}; fill_data = d;
    @(negedge clk);
    fill_valid = 1'b0;
    if (upd) model_fill(t, d);
  endtask

  task automatic look(bit [38:0] t, string req);
    bit eh;
    bit [DW-1:0] ed;
    eh = 1'b0; ed = '0;
    for (int i = 0; i < N; i++) if (m_v[i] && m_t[i] == t) begin eh = 1'b1; ed = m_d[i]; end
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = {t, 3'b011};
    #1;
    check(req, {63'd0, lk_hit}, {63'd0, eh});
    check(req, lk_data, ed);
    lk_valid = 1'b0;
  endtask

  // Issue a command and return the number of cycles busy read 1.
  task automatic command(bit [63:0] w, output int cyc);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_we = 1'b0;
    cyc = 0;
    while (cmd_rdata[0] && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic model_sweep(bit [38:0] st, bit [10:0] c);
    for (int i = 0; i < N; i++)
      if (m_v[i] && ({1'b0, m_t[i]} >= {1'b0, st}) && ({1'b0, m_t[i]} < ({1'b0, st} + 40'(c))))
        m_v[i] = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int cyc;
    bit [63:0] w;
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_t[i] = '0; m_d[i] = '0; end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cmd", cmd_rdata, 64'd0);
    check("R1 ready", {62'd0, lk_ready, fill_ready}, 64'd3);
    look(39'd0, "R1 empty");
    look(39'd100, "R1 empty");

    // R2/R4 fills past capacity, R3 in-place update
    for (int k = 0; k < N + 1; k++) fill(39'd200 + 39'(k), pat(39'd200 + 39'(k), 1), 1'b1);
    look(39'd200, "R4 oldest evicted");
    for (int k = 1; k < N + 1; k++) look(39'd200 + 39'(k), "R2 hit");
    look(39'd199, "R2 miss");
    fill(39'd203, pat(39'd203, 9), 1'b1);
    look(39'd203, "R3 update");
    fill(39'd300, pat(39'd300, 2), 1'b1);
    fill(39'd301, pat(39'd301, 2), 1'b1);
    for (int k = 0; k < N + 1; k++) look(39'd200 + 39'(k), "R3 R4 order");
    look(39'd300, "R4 new");
    look(39'd301, "R4 new");

    // R5 readback masks other bits; a write with bit 0 clear does not sweep
    w = mkcmd(39'h55_1234_5678, 11'h5A5, 1'b0) | 64'h001F_FC00_0000_0006;
    command(w, cyc);
    check("R5 readback", cmd_rdata, mkcmd(39'h55_1234_5678, 11'h5A5, 1'b0));
    check("R5 no sweep", 64'(cyc), 64'd0);

    // R6/R7/R8 near-exhaustive window sweep around entries 100..107
    for (int s = 96; s <= 110; s++) begin
      for (int c = 0; c <= 12; c++) begin
        for (int k = 0; k < N; k++) fill(39'd100 + 39'(k), pat(39'd100 + 39'(k), s + c), 1'b1);
        command(mkcmd(39'(s), 11'(c), 1'b1), cyc);
        check(c == 0 ? "R8 zero count" : "R6 busy cycles", 64'(cyc), c == 0 ? 64'd0 : 64'(N));
        model_sweep(39'(s), 11'(c));
        for (int k = 0; k < N; k++) look(39'd100 + 39'(k), c == 0 ? "R8 kept" : "R7 window");
      end
    end

    // R7 window at the very top of the tag space: no wrap
    for (int k = 0; k < N; k++) fill(39'h7F_FFFF_FFF8 + 39'(k), pat(39'(k), 7), 1'b1);
    command(mkcmd(39'h7F_FFFF_FFFC, 11'd100, 1'b1), cyc);
    model_sweep(39'h7F_FFFF_FFFC, 11'd100);
    for (int k = 0; k < N; k++) look(39'h7F_FFFF_FFF8 + 39'(k), "R7 top window");
    check("R7 top window cycles", 64'(cyc), 64'(N));

    // R9/R10 writes and traffic during a sweep
    for (int k = 0; k < N; k++) fill(39'd500 + 39'(k), pat(39'd500 + 39'(k), 3), 1'b1);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = mkcmd(39'd500, 11'd2, 1'b1);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = mkcmd(39'd0, 11'd2000, 1'b1);
    check("R10 lk_ready low", {63'd0, lk_ready}, 64'd0);
    check("R10 fill_ready low", {63'd0, fill_ready}, 64'd0);
    lk_valid = 1'b1; lk_addr = {39'd505, 3'b000};
    #1;
    check("R10 no hit while busy", {63'd0, lk_hit}, 64'd0);
    lk_valid = 1'b0;
    @(negedge clk);
    cmd_we = 1'b0;
    check("R9 fields unchanged", cmd_rdata, mkcmd(39'd500, 11'd2, 1'b1));
    fill_valid = 1'b1; fill_addr = {39'd900, 3'b000}; fill_data = 64'hDEAD;
    @(negedge clk);
    fill_valid = 1'b0;
    cyc = 3;
    while (cmd_rdata[0] && cyc < 100) begin @(negedge clk); cyc++; end
    check("R9 sweep not extended", 64'(cyc), 64'(N + 1));
    check("R9 final fields", cmd_rdata, mkcmd(39'd500, 11'd2, 1'b0));
    model_sweep(39'd500, 11'd2);
    look(39'd900, "R10 fill ignored");
    for (int k = 0; k < N; k++) look(39'd500 + 39'(k), "R9 R7 result");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule